// File: doc/BRIEF.md
# Dual-Interrupt 32-Pin GPIO Bank

The block is a bank of 32 general-purpose pins behind a 32-bit register bus. Each pin can drive a value (output data plus a per-pin direction bit) or be watched for events. The detectors are a rising edge, a falling edge, a held low level and a held high level, and any mix can be enabled per pin. One pin event sets that pin's bit in two separate status registers. Each status register has its own enable register and its own interrupt line, so two processors can service the same bank independently.

Level detectors are continuous. While a watched level holds, the status bit is re-set on every cycle, so clearing it has no lasting effect until the pin changes. Changing the direction register or a level-detect register takes effect on the next cycle. Software can update the output data, both interrupt enables and the wake enable without a read-modify-write, by writing to set and clear aliases. A wake-up request line is raised by a pin event only when the configuration arms it. Debounce registers are stored and read back but have no function.

Bus writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. Pin inputs are registered once before detection. The previous sample is kept for edge detection, so a pin change reaches the status registers two edges after it appears on `pin_in`.

Top module: `gpio_bank`

## Requirements
- R1: After reset, direction reads 0xFFFFFFFF (all pins are inputs, so `pin_oe` is 0), control reads 2, system status reads 1 and revision reads the REVISION parameter. Both enable registers, wake enable, the four detect registers, both status registers, the debounce registers, system config and output data read 0. No interrupt is raised and `wake_req` is low.
- R2: A pin event sets the same bit in status A (0x18) and in status B (0x28). Rising detect is at 0x48 and falling detect is at 0x4C. A change on `pin_in` is visible in status after the second rising clock edge.
- R3: While a pin meets its low-level (0x40) or high-level (0x44) condition, its status bit is set again on every cycle, including directly after a clearing write.
- R4: Only pins whose direction bit (0x34) is 1 produce events. A direction bit of 0 makes the pin an output.
- R5: `irq_a` is high exactly when status A AND enable A (0x1C) is non-zero. `irq_b` behaves the same way with status B and enable B (0x2C).
- R6: Writing a status register clears the bits written as 1. If an event on the same bit occurs in the same cycle, the bit stays set.
- R7: Aliases at 0x60/0x64 clear and set enable A, 0x70/0x74 do the same for enable B, 0x80/0x84 for wake enable (0x20) and 0x90/0x94 for output data (0x3C). Reading an alias returns the register it updates.
- R8: `pin_out` equals output data. `pin_oe[i]` is the inverse of direction bit i.
- R9: System config (0x10) stores the written value ANDed with 0x1D. A write with bit 1 set is a soft reset: every register returns to its R1 value except output data, and system config then takes the masked write value.
- R10: The control register (0x30) keeps bits 2:0 only.
- R11: `wake_req` rises after a pin event whose wake-enable bit is set, but only while system config bit 2 is 1 and bits 4:3 are non-zero. It then stays high until the next system config write or reset.
- R12: Writes to revision (0x00), system status (0x14) and input data (0x38) are ignored. Input data reads the registered pin sample. Debounce enable (0x50) and debounce time (0x54, 8 bits) read back what was written. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Pin input levels |
| pin_out | output | 32 | Output data driven to the pins |
| pin_oe | output | 32 | Per-pin output enable, active high |
| irq_a | output | 1 | Interrupt line A |
| irq_b | output | 1 | Interrupt line B |
| wake_req | output | 1 | Wake-up request |

## Verification
The assertions check four properties on every cycle. A status bit never drops without a status write or a soft reset. Every detector hit lands in both status registers. Pins configured as outputs never produce an event. The wake line holds until a config write and rises only under an armed configuration. The bench's scenarios are needed for the rest: alias arithmetic on the stored registers, level re-arming right after a clear, the config mask and the soft reset sparing output data, the control width, and register read-back. A behavioural model compares every output and the read data on each cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int GPIO_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int NUM_IRQ = 2;
  localparam int CFG_W   = 5;
  localparam int CTRL_W  = 3;
  localparam int DBT_W   = 8;
  localparam int CHAN_STRIDE = 'h10;

  localparam logic [ADDR_W-1:0] OFS_REV     = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_SYSCFG  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SYSSTAT = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_STAT_A  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_EN_A    = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_WAKE_EN = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_DIR     = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_DIN     = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_DOUT    = 8'h3C;
  localparam logic [ADDR_W-1:0] OFS_LVL_LO  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_LVL_HI  = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_RISE    = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_FALL    = 8'h4C;
  localparam logic [ADDR_W-1:0] OFS_DB_EN   = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_DB_TIME = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_EN_A_CLR = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_EN_A_SET = 8'h64;
  localparam logic [ADDR_W-1:0] OFS_WK_CLR   = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_WK_SET   = 8'h84;
  localparam logic [ADDR_W-1:0] OFS_DOUT_CLR = 8'h90;
  localparam logic [ADDR_W-1:0] OFS_DOUT_SET = 8'h94;

  localparam logic [CFG_W-1:0]  CFG_KEEP   = 5'h1D;
  localparam int                CFG_SRST   = 1;
  localparam int                CFG_WAKEON = 2;
  localparam logic [CTRL_W-1:0] CTRL_RST   = 3'd2;

  // Per-pin detector hits for one sampled cycle.
  function automatic logic [GPIO_W-1:0] pin_events(
    input logic [GPIO_W-1:0] cur, input logic [GPIO_W-1:0] prev,
    input logic [GPIO_W-1:0] is_in,
    input logic [GPIO_W-1:0] lo, input logic [GPIO_W-1:0] hi,
    input logic [GPIO_W-1:0] rise, input logic [GPIO_W-1:0] fall);
    logic [GPIO_W-1:0] up, down;
    up   = cur & ~prev;
    down = ~cur & prev;
    return is_in & ((rise & up) | (fall & down) | (hi & cur) | (lo & ~cur));
  endfunction

  // Set/clear alias update of a stored mask.
  function automatic logic [GPIO_W-1:0] alias_update(
    input logic [GPIO_W-1:0] cur, input logic [GPIO_W-1:0] wdata,
    input logic do_set, input logic do_clr);
    logic [GPIO_W-1:0] r;
    r = cur;
    if (do_set) r = r | wdata;
    if (do_clr) r = r & ~wdata;
    return r;
  endfunction

  function automatic logic wake_armed(input logic [CFG_W-1:0] cfg);
    return cfg[CFG_WAKEON] && (cfg[4:3] != 2'b00);
  endfunction
endpackage

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GPIO_W-1:0] pin_in,
  input  logic [GPIO_W-1:0] is_in,
  input  logic [GPIO_W-1:0] lvl_lo,
  input  logic [GPIO_W-1:0] lvl_hi,
  input  logic [GPIO_W-1:0] det_rise,
  input  logic [GPIO_W-1:0] det_fall,
  output logic [GPIO_W-1:0] pin_now,
  output logic [GPIO_W-1:0] events
);
  logic [GPIO_W-1:0] pin_q, pin_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q    <= '0;
      pin_prev <= '0;
    end else begin
      pin_q    <= pin_in;
      pin_prev <= pin_q;
    end
  end

  assign pin_now = pin_q;
  assign events  = pin_events(pin_q, pin_prev, is_in, lvl_lo, lvl_hi,
                              det_rise, det_fall);
endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [GPIO_W-1:0] events,
  input  logic [GPIO_W-1:0] wdata,
  input  logic              wr_status,
  input  logic              wr_enable,
  input  logic              wr_en_set,
  input  logic              wr_en_clr,
  output logic [GPIO_W-1:0] status,
  output logic [GPIO_W-1:0] enable,
  output logic              irq
);
  logic [GPIO_W-1:0] clr_mask;
  assign clr_mask = wr_status ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else if (soft_rst) begin
      status <= '0;
      enable <= '0;
    end else begin
      // A same-cycle event outranks the clear.
      status <= (status & ~clr_mask) | events;
      if (wr_enable) enable <= wdata;
      else           enable <= alias_update(enable, wdata, wr_en_set, wr_en_clr);
    end
  end

  assign irq = |(status & enable);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter logic [7:0] REVISION = 8'h25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [GPIO_W-1:0] bus_wdata,
  output logic [GPIO_W-1:0] bus_rdata,
  input  logic [GPIO_W-1:0] pin_in,
  output logic [GPIO_W-1:0] pin_out,
  output logic [GPIO_W-1:0] pin_oe,
  output logic              irq_a,
  output logic              irq_b,
  output logic              wake_req
);
  logic [CFG_W-1:0]  cfg_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DBT_W-1:0]  dbt_q;
  logic [GPIO_W-1:0] dir_q, dout_q, lo_q, hi_q, rise_q, fall_q, dben_q, wken_q;
  logic [GPIO_W-1:0] pin_now, ev;
  logic              wake_q;
  logic [NUM_IRQ-1:0][GPIO_W-1:0] chan_status, chan_enable;
  logic [NUM_IRQ-1:0]             chan_irq, wr_stat;

  logic cfg_wr, soft_rst;
  function automatic logic hit(input logic [ADDR_W-1:0] ofs);
    return bus_wr && (bus_addr == ofs);
  endfunction
  assign cfg_wr   = hit(OFS_SYSCFG);
  assign soft_rst = cfg_wr && bus_wdata[CFG_SRST];

  gpio_pin_sense u_sense (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .is_in(dir_q),
    .lvl_lo(lo_q), .lvl_hi(hi_q), .det_rise(rise_q), .det_fall(fall_q),
    .pin_now(pin_now), .events(ev)
  );

  for (genvar c = 0; c < NUM_IRQ; c++) begin : g_chan
    localparam logic [ADDR_W-1:0] SH = ADDR_W'(c * CHAN_STRIDE);
    assign wr_stat[c] = hit(OFS_STAT_A + SH);
    gpio_irq_chan u_chan (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .events(ev),
      .wdata(bus_wdata), .wr_status(wr_stat[c]),
      .wr_enable(hit(OFS_EN_A + SH)),
      .wr_en_set(hit(OFS_EN_A_SET + SH)),
      .wr_en_clr(hit(OFS_EN_A_CLR + SH)),
      .status(chan_status[c]), .enable(chan_enable[c]), .irq(chan_irq[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; ctrl_q <= CTRL_RST; dbt_q <= '0;
      dir_q <= '1; dout_q <= '0; lo_q <= '0; hi_q <= '0;
      rise_q <= '0; fall_q <= '0; dben_q <= '0; wken_q <= '0;
      wake_q <= 1'b0;
    end else if (soft_rst) begin
      cfg_q <= bus_wdata[CFG_W-1:0] & CFG_KEEP;
      ctrl_q <= CTRL_RST; dbt_q <= '0; dir_q <= '1;
      lo_q <= '0; hi_q <= '0; rise_q <= '0; fall_q <= '0;
      dben_q <= '0; wken_q <= '0; wake_q <= 1'b0;
    end else begin
      if (cfg_wr)           cfg_q  <= bus_wdata[CFG_W-1:0] & CFG_KEEP;
      if (hit(OFS_CTRL))    ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (hit(OFS_DIR))     dir_q  <= bus_wdata;
      if (hit(OFS_LVL_LO))  lo_q   <= bus_wdata;
      if (hit(OFS_LVL_HI))  hi_q   <= bus_wdata;
      if (hit(OFS_RISE))    rise_q <= bus_wdata;
      if (hit(OFS_FALL))    fall_q <= bus_wdata;
      if (hit(OFS_DB_EN))   dben_q <= bus_wdata;
      if (hit(OFS_DB_TIME)) dbt_q  <= bus_wdata[DBT_W-1:0];
      if (hit(OFS_DOUT)) dout_q <= bus_wdata;
      else dout_q <= alias_update(dout_q, bus_wdata, hit(OFS_DOUT_SET), hit(OFS_DOUT_CLR));
      if (hit(OFS_WAKE_EN)) wken_q <= bus_wdata;
      else wken_q <= alias_update(wken_q, bus_wdata, hit(OFS_WK_SET), hit(OFS_WK_CLR));
      if (cfg_wr)
        wake_q <= 1'b0;
      else if (wake_armed(cfg_q) && |(ev & wken_q))
        wake_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_REV:                              bus_rdata = GPIO_W'(REVISION);
      OFS_SYSCFG:                           bus_rdata = GPIO_W'(cfg_q);
      OFS_SYSSTAT:                          bus_rdata = GPIO_W'(1);
      OFS_STAT_A:                           bus_rdata = chan_status[0];
      OFS_STAT_A + 8'h10:                   bus_rdata = chan_status[1];
      OFS_EN_A, OFS_EN_A_CLR, OFS_EN_A_SET: bus_rdata = chan_enable[0];
      OFS_EN_A + 8'h10, OFS_EN_A_CLR + 8'h10,
      OFS_EN_A_SET + 8'h10:                 bus_rdata = chan_enable[1];
      OFS_WAKE_EN, OFS_WK_CLR, OFS_WK_SET:  bus_rdata = wken_q;
      OFS_CTRL:                             bus_rdata = GPIO_W'(ctrl_q);
      OFS_DIR:                              bus_rdata = dir_q;
      OFS_DIN:                              bus_rdata = pin_now;
      OFS_DOUT, OFS_DOUT_CLR, OFS_DOUT_SET: bus_rdata = dout_q;
      OFS_LVL_LO:                           bus_rdata = lo_q;
      OFS_LVL_HI:                           bus_rdata = hi_q;
      OFS_RISE:                             bus_rdata = rise_q;
      OFS_FALL:                             bus_rdata = fall_q;
      OFS_DB_EN:                            bus_rdata = dben_q;
      OFS_DB_TIME:                          bus_rdata = GPIO_W'(dbt_q);
      default:                              bus_rdata = '0;
    endcase
  end

  assign pin_out  = dout_q;
  assign pin_oe   = ~dir_q;
  assign irq_a    = chan_irq[0];
  assign irq_b    = chan_irq[1];
  assign wake_req = wake_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [GPIO_W-1:0] ev,
  input logic [GPIO_W-1:0] st_a,
  input logic [GPIO_W-1:0] st_b,
  input logic              wr_stat_a,
  input logic              wr_stat_b,
  input logic              soft_rst,
  input logic [GPIO_W-1:0] dir_q,
  input logic [CFG_W-1:0]  cfg_q,
  input logic              cfg_wr,
  input logic              wake_req
);
  // R6: status bits only drop through a status write or soft reset
  assert_sticky_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stat_a && !soft_rst) |=> ((st_a & $past(st_a)) == $past(st_a)));
  assert_sticky_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stat_b && !soft_rst) |=> ((st_b & $past(st_b)) == $past(st_b)));
  // R2: a detector hit reaches both status registers
  assert_both_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && ev != '0) |=>
      (((st_a & $past(ev)) == $past(ev)) && ((st_b & $past(ev)) == $past(ev))));
  // R4: output pins never produce an event
  assert_no_output_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev & ~dir_q) == '0));
  // R11: wake holds until a config write
  assert_wake_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !cfg_wr) |=> wake_req);
  // R11: wake only rises under an armed configuration
  assert_wake_armed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> ($past(cfg_q[CFG_WAKEON]) && ($past(cfg_q[4:3]) != 2'b00)));
endmodule

bind gpio_bank gpio_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev(ev),
  .st_a(chan_status[0]), .st_b(chan_status[1]),
  .wr_stat_a(wr_stat[0]), .wr_stat_b(wr_stat[1]),
  .soft_rst(soft_rst), .dir_q(dir_q), .cfg_q(cfg_q),
  .cfg_wr(cfg_wr), .wake_req(wake_req)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  localparam logic [7:0] REV = 8'h25;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq_a, irq_b, wake_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_bank #(.REVISION(REV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_a(irq_a), .irq_b(irq_b),
    .wake_req(wake_req)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_q, m_q2, m_dir, m_dout, m_lo, m_hi, m_rise, m_fall;
  logic [31:0] m_dben, m_wen, m_sa, m_sb, m_ea, m_eb;
  logic [4:0]  m_cfg;
  logic [2:0]  m_ctrl;
  logic [7:0]  m_dbt;
  logic        m_wake;

  task automatic m_defaults();
    m_cfg = 0; m_ctrl = 2; m_dbt = 0; m_dir = '1; m_lo = 0; m_hi = 0;
    m_rise = 0; m_fall = 0; m_dben = 0; m_wen = 0; m_sa = 0; m_sb = 0;
    m_ea = 0; m_eb = 0; m_wake = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_defaults(); m_dout = 0; m_q = 0; m_q2 = 0;
    end else begin
      logic [31:0] hits;
      logic [31:0] d;
      bit armed;
      hits = 0;
      for (int i = 0; i < 32; i++) begin
        bit now, was;
        now = m_q[i]; was = m_q2[i];
        if (m_dir[i] && ((m_rise[i] && now && !was) || (m_fall[i] && !now && was)
                         || (m_hi[i] && now) || (m_lo[i] && !now)))
          hits[i] = 1'b1;
      end
      armed = m_cfg[2] && (m_cfg[4] || m_cfg[3]);
      d = bus_wdata;
      if (bus_wr && bus_addr == 8'h10 && d[1]) begin
        m_defaults(); m_cfg = d[4:0] & 5'h1D;
      end else begin
        if (bus_wr) begin
          case (bus_addr)
            8'h10: m_cfg = d[4:0] & 5'h1D;
            8'h18: m_sa = m_sa & ~d;
            8'h28: m_sb = m_sb & ~d;
            8'h1C: m_ea = d;
            8'h2C: m_eb = d;
            8'h60: m_ea = m_ea & ~d;
            8'h64: m_ea = m_ea | d;
            8'h70: m_eb = m_eb & ~d;
            8'h74: m_eb = m_eb | d;
            8'h20: m_wen = d;
            8'h80: m_wen = m_wen & ~d;
            8'h84: m_wen = m_wen | d;
            8'h30: m_ctrl = d[2:0];
            8'h34: m_dir = d;
            8'h3C: m_dout = d;
            8'h90: m_dout = m_dout & ~d;
            8'h94: m_dout = m_dout | d;
            8'h40: m_lo = d;
            8'h44: m_hi = d;
            8'h48: m_rise = d;
            8'h4C: m_fall = d;
            8'h50: m_dben = d;
            8'h54: m_dbt = d[7:0];
            default: ;
          endcase
        end
        m_sa = m_sa | hits;
        m_sb = m_sb | hits;
        if (bus_wr && bus_addr == 8'h10) m_wake = 0;
        else if (armed && (hits & m_wen) != 0) m_wake = 1;
      end
      m_q2 = m_q;
      m_q = pin_in;
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return {24'h0, REV};
      8'h10: return {27'h0, m_cfg};
      8'h14: return 32'h1;
      8'h18: return m_sa;
      8'h28: return m_sb;
      8'h1C, 8'h60, 8'h64: return m_ea;
      8'h2C, 8'h70, 8'h74: return m_eb;
      8'h20, 8'h80, 8'h84: return m_wen;
      8'h30: return {29'h0, m_ctrl};
      8'h34: return m_dir;
      8'h38: return m_q;
      8'h3C, 8'h90, 8'h94: return m_dout;
      8'h40: return m_lo;
      8'h44: return m_hi;
      8'h48: return m_rise;
      8'h4C: return m_fall;
      8'h50: return m_dben;
      8'h54: return {24'h0, m_dbt};
      default: return 32'h0;
    endcase
  endfunction

  // Cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #5;
      checks++;
      if (pin_out !== m_dout || pin_oe !== ~m_dir || irq_a !== ((m_sa & m_ea) != 0)
          || irq_b !== ((m_sb & m_eb) != 0) || wake_req !== m_wake
          || bus_rdata !== m_read(bus_addr)) begin
        errors++;
        $display("FAIL model R5/R8 addr=%h: got out=%h oe=%h ia=%b ib=%b wk=%b rd=%h exp out=%h oe=%h ia=%b ib=%b wk=%b rd=%h",
          bus_addr, pin_out, pin_oe, irq_a, irq_b, wake_req, bus_rdata,
          m_dout, ~m_dir, (m_sa & m_ea) != 0, (m_sb & m_eb) != 0, m_wake, m_read(bus_addr));
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #3; d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h34, v); chk("R1 dir", v, 32'hFFFF_FFFF);
    rd(8'h30, v); chk("R1 ctrl", v, 32'h2);
    rd(8'h14, v); chk("R1 sysstat", v, 32'h1);
    rd(8'h00, v); chk("R1 revision", v, {24'h0, REV});
    rd(8'h18, v); chk("R1 status A", v, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 irq/wake", {29'h0, irq_a, irq_b, wake_req}, 0);

    // R8 and R7 output data
    wr(8'h34, 32'hFFFF_0000);
    wr(8'h3C, 32'h0000_A5A5);
    chk("R8 pin_oe", pin_oe, 32'h0000_FFFF);
    chk("R8 pin_out", pin_out, 32'h0000_A5A5);
    wr(8'h94, 32'h2);
    rd(8'h94, v); chk("R7 dout set alias", v, 32'h0000_A5A7);
    wr(8'h90, 32'h1);
    rd(8'h3C, v); chk("R7 dout clear alias", v, 32'h0000_A5A6);

    // R2/R5 rising edge on pin 16 into both status registers
    wr(8'h48, 32'h0001_0000);
    wr(8'h1C, 32'h0001_0000);
    @(negedge clk) pin_in[16] = 1'b1;
    settle();
    rd(8'h18, v); chk("R2 status A", v, 32'h0001_0000);
    rd(8'h28, v); chk("R2 status B", v, 32'h0001_0000);
    chk("R5 irq_a high", {31'h0, irq_a}, 1);
    chk("R5 irq_b low (enable B clear)", {31'h0, irq_b}, 0);
    wr(8'h74, 32'h0001_0000);
    chk("R5 irq_b after enable set", {31'h0, irq_b}, 1);
    rd(8'h2C, v); chk("R7 enable B", v, 32'h0001_0000);

    // R6 clear
    wr(8'h18, 32'h0001_0000);
    rd(8'h18, v); chk("R6 status A cleared", v, 0);
    chk("R6 irq_a low", {31'h0, irq_a}, 0);
    rd(8'h28, v); chk("R6 status B kept", v, 32'h0001_0000);

    // R3 level re-set after clear (same-cycle event wins, R6)
    wr(8'h44, 32'h0002_0000);
    @(negedge clk) pin_in[17] = 1'b1;
    settle();
    wr(8'h18, 32'h0002_0000);
    rd(8'h18, v); chk("R3 level re-set", v, 32'h0002_0000);
    @(negedge clk) pin_in[17] = 1'b0;
    settle();
    wr(8'h18, 32'h0002_0000);
    rd(8'h18, v); chk("R3 cleared once level gone", v, 0);

    // R4 output pin gives no event
    wr(8'h34, 32'hFFFB_0000);
    wr(8'h48, 32'h0005_0000);
    @(negedge clk) pin_in[18] = 1'b1;
    settle();
    rd(8'h18, v); chk("R4 output pin ignored", v, 0);

    // R11 wake gating and hold
    wr(8'h84, 32'h0001_0000);
    wr(8'h4C, 32'h0001_0000);
    rd(8'h80, v); chk("R7 wake enable alias read", v, 32'h0001_0000);
    wr(8'h10, 32'h04);
    @(negedge clk) pin_in[16] = 1'b0;
    settle();
    chk("R11 no wake with idle bits zero", {31'h0, wake_req}, 0);
    @(negedge clk) pin_in[16] = 1'b1;
    settle();
    wr(8'h10, 32'h0C);
    rd(8'h10, v); chk("R9 config stored", v, 32'h0C);
    @(negedge clk) pin_in[16] = 1'b0;
    settle();
    chk("R11 wake raised", {31'h0, wake_req}, 1);
    repeat (4) @(negedge clk);
    chk("R11 wake held", {31'h0, wake_req}, 1);
    wr(8'h10, 32'h0C);
    chk("R11 wake cleared by config write", {31'h0, wake_req}, 0);

    // R10 and R12
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, v); chk("R10 ctrl 3 bits", v, 32'h7);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R12 revision read-only", v, {24'h0, REV});
    wr(8'h14, 32'h0);
    rd(8'h14, v); chk("R12 sysstat read-only", v, 32'h1);
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, v); chk("R12 input data", v, 32'h0005_0000 & ~32'h0001_0000);
    wr(8'h50, 32'hDEAD_BEEF);
    rd(8'h50, v); chk("R12 debounce enable", v, 32'hDEAD_BEEF);
    wr(8'h54, 32'h0000_0133);
    rd(8'h54, v); chk("R12 debounce time", v, 32'h33);
    rd(8'h5C, v); chk("R12 unmapped", v, 0);

    // R9 soft reset keeps output data
    wr(8'h10, 32'hFF);
    rd(8'h10, v); chk("R9 config mask", v, 32'h1D);
    rd(8'h34, v); chk("R9 dir reset", v, 32'hFFFF_FFFF);
    rd(8'h1C, v); chk("R9 enable A reset", v, 0);
    rd(8'h28, v); chk("R9 status B reset", v, 0);
    rd(8'h30, v); chk("R9 ctrl reset", v, 32'h2);
    rd(8'h3C, v); chk("R9 output data kept", v, 32'h0000_A5A6);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule